// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 64K words of 16 bits each. The host presents a request with a word address, a direction, write data and a two-bit lane mask. The controller then runs the memory's strobes as a short, fixed sequence of clock-counted phases and pulses a one-cycle completion flag. After a read, the returned word is valid from that completion pulse until the next completion.

The memory has no clock, so every timing rule becomes a count of controller clocks. `READ_CYCLES` sets how long the read strobes stay low before the data is sampled. `WP_CYCLES` sets the width of the write strobe. `TURN_CYCLES` sets how long the memory's output enable must have been released before the controller's own data driver switches on. The data bus is split into a driven value, a drive-enable and a sampled value, so the pad buffer can be placed outside this block.

The lane mask works as follows. Bit 0 selects data bits 7:0 through the lower lane enable. Bit 1 selects data bits 15:8 through the upper lane enable. A mask of zero finishes at once and does not touch the memory.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, chip enable, output enable, write enable and both lane enables are high (inactive), the data drive-enable is low and `req_ready` is low.
- R2: A read with a non-zero mask holds chip enable low, output enable low and write enable high. The lower lane enable is driven low exactly when mask bit 0 is 1, and the upper lane enable exactly when mask bit 1 is 1. `req_ready` rises `READ_CYCLES`+1 clocks after the edge that accepts the request.
- R3: On read completion, `rsp_rdata[7:0]` holds the memory's lower lane if mask bit 0 was set and zero otherwise. `rsp_rdata[15:8]` holds the upper lane if mask bit 1 was set and zero otherwise. The value is held until the next completion.
- R4: A write changes only the lanes whose mask bit is 1. The other lane of that word keeps its previous content.
- R5: During a write, chip enable stays low throughout. Write enable is low for exactly `WP_CYCLES` clocks, and the data driver is on for every one of those clocks. `req_ready` rises `TURN_CYCLES`+`WP_CYCLES`+1 clocks after the accepting edge.
- R6: The data driver is never on while output enable is low. It switches on only after output enable has been high for at least `TURN_CYCLES` clocks.
- R7: A request with mask 00 completes with `req_ready` on the clock after acceptance. Chip enable is never asserted for it, and `rsp_rdata` is left unchanged.
- R8: `req_ready` is high for exactly one clock per request. A request is accepted only when the controller is idle and `req_ready` is low.
- R9: While chip enable is high, every other strobe is inactive and the driver is off. While chip enable stays low, the memory address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; hold until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, lanes not selected are zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data sampled from the memory bus |

## Verification
The hardest situation to reach is a write that follows a read as closely as the handshake allows. There the release of output enable and the switch-on of the data driver are only a few clocks apart, and any counting slip shows up as bus contention. The stimulus reaches it with directed read-then-write pairs on the same word. Randomly mixed operations then create many more such back-to-back turns. A bench memory model flags any write strobe without driven data, and any overlap of the driver with output enable. Single-lane writes are followed by full-width reads, so a lane that was written when it should have been skipped shows up as a data miscompare.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W      = 16,
  parameter int READ_CYCLES = 2,
  parameter int WP_CYCLES   = 2,
  parameter int TURN_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              req_ready,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int MAXC  = (READ_CYCLES > WP_CYCLES) ?
                         ((READ_CYCLES > TURN_CYCLES) ? READ_CYCLES : TURN_CYCLES) :
                         ((WP_CYCLES > TURN_CYCLES) ? WP_CYCLES : TURN_CYCLES);
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    IDLE, READ_WAIT, READ_CAPTURE, WRITE_SETUP, WRITE_PULSE, WRITE_END
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cnt_done;

  assign accept   = (state == IDLE) && req_valid && !req_ready;
  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      cnt        <= '0;
      req_ready  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      case (state)
        IDLE: begin
          if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            if (req_mask == 2'b00) begin
              req_ready <= 1'b1;
            end else begin
              mem_ce_n <= 1'b0;
              mem_lb_n <= ~req_mask[0];
              mem_ub_n <= ~req_mask[1];
              if (req_write) begin
                cnt   <= CNT_W'(TURN_CYCLES - 1);
                state <= WRITE_SETUP;
              end else begin
                mem_oe_n <= 1'b0;
                cnt      <= CNT_W'(READ_CYCLES - 1);
                state    <= READ_WAIT;
              end
            end
          end
        end
        READ_WAIT: begin
          if (cnt_done) state <= READ_CAPTURE;
          else          cnt   <= cnt - 1'b1;
        end
        READ_CAPTURE: begin
          rsp_rdata <= {mem_ub_n ? 8'h00 : mem_dq_in[15:8],
                        mem_lb_n ? 8'h00 : mem_dq_in[7:0]};
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          req_ready <= 1'b1;
          state     <= IDLE;
        end
        WRITE_SETUP: begin
          if (cnt_done) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            cnt       <= CNT_W'(WP_CYCLES - 1);
            state     <= WRITE_PULSE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WRITE_PULSE: begin
          if (cnt_done) begin
            mem_we_n <= 1'b1;
            state    <= WRITE_END;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        WRITE_END: begin
          mem_dq_oe <= 1'b0;
          mem_ce_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          req_ready <= 1'b1;
          state     <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W      = 16,
  parameter int WP_CYCLES   = 2,
  parameter int TURN_CYCLES = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              mem_dq_oe
);
  logic [31:0] we_lo;
  logic [31:0] oe_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_lo <= '0;
      oe_hi <= '0;
    end else begin
      we_lo <= mem_we_n ? 32'd0 : we_lo + 32'd1;
      if (!mem_oe_n)            oe_hi <= '0;
      else if (oe_hi != '1)     oe_hi <= oe_hi + 32'd1;
    end
  end

  a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));
  a_r5_pulse_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_ce_n && mem_oe_n));
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo == WP_CYCLES));
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi >= TURN_CYCLES));
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe && mem_lb_n && mem_ub_n));
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W), .WP_CYCLES(WP_CYCLES), .TURN_CYCLES(TURN_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 2;
  localparam int WP = 2;
  localparam int TC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = 16'h5AA5;

  int n_vec = 0;
  int n_bad = 0;
  int ce_lo_cnt = 0;
  int we_lo_cnt = 0;
  int oe_hi_run = 0;
  bit done = 1'b0;
  logic [15:0] last_rdata = '0;

  logic [15:0] mem_m [logic [15:0]];
  logic [15:0] ref_m [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(16), .READ_CYCLES(RC), .WP_CYCLES(WP), .TURN_CYCLES(TC)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [15:0] init_val(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  function automatic logic [15:0] mem_rd(input logic [15:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_m.exists(a) ? ref_m[a] : init_val(a);
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] lane_sel(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench memory model and bus monitors
  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n) begin
      logic [15:0] cur;
      if (!mem_dq_oe) begin
        n_bad++;
        $display("FAIL R5 write strobe without drive actual=%0h expected=%0h", mem_dq_oe, 1);
      end
      cur = mem_rd(mem_addr);
      if (!mem_lb_n) cur[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) cur[15:8] = mem_dq_out[15:8];
      mem_m[mem_addr] = cur;
    end
  end

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      logic [15:0] v;
      v = mem_rd(mem_addr);
      mem_dq_in <= {mem_ub_n ? 8'hA5 : v[15:8], mem_lb_n ? 8'hA5 : v[7:0]};
    end else begin
      mem_dq_in <= 16'h5AA5;
    end
    if (rst_n) begin
      if (!mem_ce_n) ce_lo_cnt++;
      if (!mem_we_n) we_lo_cnt++;
      if (mem_dq_oe && !mem_oe_n) begin
        n_bad++;
        $display("FAIL R6 driver on with output enable low actual=%0h expected=%0h", 1, 0);
      end
      if (mem_dq_oe && oe_hi_run < TC) begin
        n_bad++;
        $display("FAIL R6 turnaround too short actual=%0d expected=%0d", oe_hi_run, TC);
      end
      oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
    end
  end

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    int cyc;
    int ce0;
    int we0;
    int exp_lat;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    ce0 = ce_lo_cnt;
    we0 = we_lo_cnt;
    cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (req_ready || cyc > 60) break;
    end
    req_valid = 1'b0;
    exp_lat = (m == 2'b00) ? 1 : (wr ? TC + WP + 2 : RC + 2);
    if (m == 2'b00) begin
      check(cyc == exp_lat, "R7 noop latency", cyc, exp_lat);
      check(ce_lo_cnt == ce0, "R7 chip enable untouched", ce_lo_cnt - ce0, 0);
      check(rsp_rdata == last_rdata, "R7 read data kept", rsp_rdata, last_rdata);
    end else if (wr) begin
      check(cyc == exp_lat, "R5 write latency", cyc, exp_lat);
      check(we_lo_cnt - we0 == WP, "R5 write pulse width", we_lo_cnt - we0, WP);
      ref_m[a] = merge(ref_rd(a), d, m);
    end else begin
      check(cyc == exp_lat, "R2 read latency", cyc, exp_lat);
      check(rsp_rdata == lane_sel(ref_rd(a), m), "R3 read data", rsp_rdata,
            lane_sel(ref_rd(a), m));
      last_rdata = rsp_rdata;
    end
    @(negedge clk);
    check(!req_ready, "R8 ready single pulse", req_ready, 0);
  endtask

  task automatic check_read_strobes(input logic [15:0] a, input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
    @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b001, "R2 read strobes",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
    check({mem_ub_n, mem_lb_n} == ~m, "R2 lane enables", {mem_ub_n, mem_lb_n}, ~m);
    check(mem_addr == a, "R9 address", mem_addr, a);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b0;
    last_rdata = rsp_rdata;
    check(rsp_rdata == lane_sel(ref_rd(a), m), "R3 read data strobed", rsp_rdata,
          lane_sel(ref_rd(a), m));
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'h1F, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_dq_oe && !req_ready && mem_ce_n && mem_oe_n && mem_we_n,
          "R1 idle after reset", {mem_dq_oe, req_ready, mem_ce_n}, 3'b001);

    do_op(1'b1, 16'h0000, 16'hBEEF, 2'b11);
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11);
    do_op(1'b1, 16'h0000, 16'h1234, 2'b01);
    do_op(1'b0, 16'h0000, 16'h0000, 2'b11);  // R4 upper lane kept
    do_op(1'b1, 16'hFFFF, 16'hCAFE, 2'b10);
    do_op(1'b0, 16'hFFFF, 16'h0000, 2'b11);  // R4 lower lane kept
    do_op(1'b0, 16'hFFFF, 16'h0000, 2'b01);  // R3 upper lane zero
    do_op(1'b0, 16'hFFFF, 16'h0000, 2'b10);  // R3 lower lane zero
    do_op(1'b1, 16'h0040, 16'h7777, 2'b00);  // R7 noop write
    do_op(1'b0, 16'h0040, 16'h0000, 2'b11);
    do_op(1'b0, 16'h0040, 16'h0000, 2'b00);  // R7 noop read
    do_op(1'b0, 16'h0100, 16'h0000, 2'b11);  // R6 read then write
    do_op(1'b1, 16'h0100, 16'h0F0F, 2'b11);
    do_op(1'b0, 16'h0100, 16'h0000, 2'b11);
    check_read_strobes(16'h0100, 2'b10);
    check_read_strobes(16'h0000, 2'b01);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = {$urandom_range(0, 3) == 0 ? 8'hFF : 8'h12, 4'h0, 4'($urandom_range(0, 7))};
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule